// File: doc/BRIEF.md
# External Bus Cycle Engine

This block carries out external memory accesses for an on-chip requester, one at a time. A request brings an address, a 16-bit write word, a direction flag and its own bus configuration. That configuration sets the bus mode, the number of wait states, whether the ready line is used and the ready line's active level. The engine then drives the external address, data, latch and strobe lines cycle by cycle. It returns the read word together with a single-cycle completion pulse.

There are four bus modes. Address and data either share one set of lines (multiplexed) or use separate lines (demultiplexed), and the data path is either 16 or 8 bits wide. A word access on an 8-bit data path is done as two byte cycles. The configuration travels with each request, so two accesses in a row may use different modes and timings without any setup in between. Upper address lines above bit 15 come out on a segment port. Only the lowest `SEG_ACT` of them follow the address, which sets the size of the reachable space.

Top module: `xbus_engine`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `ale`, `xad_oe` and `rsp_done` are 0 and `rd_n` and `wr_n` are 1.
- R2: `cfg_mode` bit 0 = 0 selects demultiplexed mode. The word address (`req_addr[15:1]`, bit 0 forced to 0 on a 16-bit path) is on `bus_a` for the whole access, `ale` stays 0, and `rd_n` and `wr_n` are never low together.
- R3: `cfg_mode` bit 0 = 1 selects multiplexed mode. Each byte or word cycle begins with `ale` high for exactly one clock with the address on `xad_out` and `xad_oe` = 1. The address is held one more clock with `ale` low before the strobe.
- R4: `cfg_mode` bit 1 = 1 selects the 8-bit data path. In the data phase only `xad_out[7:0]` carries write data, and the upper byte is driven 0. On reads only `xad_in[7:0]` is used.
- R5: A word access on the 8-bit path runs two byte cycles: the even address (bit 0 = 0) with the low byte first, then the odd address with the high byte. `rsp_done` pulses once, after the second cycle.
- R6: With ready disabled, the strobe (`rd_n` or `wr_n` low) lasts exactly `cfg_wait`+1 clocks.
- R7: With `cfg_rdy_en` = 1, the strobe ends only once the wait states are used up and the ready level has passed a two-flop synchronizer. If `bus_rdy` becomes active late, the strobe rises at the third rising edge after that. `cfg_rdy_pol` = 1 means active high and 0 means active low.
- R8: Read data is taken on the last strobe clock and held on `rsp_data`. `rsp_done` is high for one clock, in the cycle after the last bus phase.
- R9: On writes `xad_oe` is high while `wr_n` is low and for one hold clock after `wr_n` rises. On reads `xad_oe` is 0 while `rd_n` is low.
- R10: During an access, `bus_seg[i]` equals `req_addr[16+i]` for i < `SEG_ACT` (default 7) and is 0 for higher i.
- R11: A request is taken on any clock where `busy` is 0, including the clock in which `rsp_done` is high. `req_valid` while `busy` is 1 has no effect on the access in progress and starts no later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_addr | input | LOW_AW+SEG_MAX | Byte address of the word |
| req_wdata | input | DATA_W | Write word |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_mode | input | 2 | Bit 0 multiplexed, bit 1 8-bit path |
| cfg_wait | input | WAIT_W | Wait states added to the strobe |
| cfg_rdy_en | input | 1 | Use the ready input |
| cfg_rdy_pol | input | 1 | Ready active level |
| busy | output | 1 | Access in progress |
| rsp_data | output | DATA_W | Last read word |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_a | output | LOW_AW | Dedicated address lines (demultiplexed) |
| bus_seg | output | SEG_MAX | Segment address lines |
| xad_out | output | DATA_W | Data or shared address/data out |
| xad_in | input | DATA_W | Data in from the bus |
| xad_oe | output | 1 | Output enable for `xad_out` |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_rdy | input | 1 | Asynchronous ready from the device |

## Verification
The completion pulse of one access and the start of the next access can land in the same clock. The bench provokes this by presenting a second request, with a different bus mode, in the very cycle it sees `rsp_done` from a multiplexed read. It then checks that `busy` is high on the next clock and that the 8-bit demultiplexed write that follows puts the right addresses and byte lanes on the bus. It also checks the ready extension against the synchronizer delay, counting strobe clocks after `bus_rdy` turns active under both polarities.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALE,
      ST_AHOLD,
      ST_STRB,
      ST_WHOLD
   } xbus_st_e;

   // cfg_mode[1] = narrow (8-bit path), cfg_mode[0] = shared address/data
   typedef struct packed {
      logic narrow;
      logic mux;
   } xbus_mode_t;
endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xbus_rdy_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_addr_map.sv
module xbus_addr_map #(
   parameter int LOW_AW  = 16,
   parameter int SEG_MAX = 8,
   parameter int SEG_ACT = 7,
   localparam int ADDR_W = LOW_AW + SEG_MAX
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               narrow,
   input  logic               byte_sel,
   output logic [LOW_AW-1:0]  low,
   output logic [SEG_MAX-1:0] seg
);
   generate
      if (SEG_ACT > SEG_MAX) begin : g_bad_seg
         $error("xbus_addr_map: SEG_ACT exceeds SEG_MAX");
      end
   endgenerate

   logic unused_addr;
   assign unused_addr = ^addr;

   // bit 0 comes from the byte index on a narrow path, else word aligned
   assign low = {addr[LOW_AW-1:1], narrow & byte_sel};

   generate
      for (genvar i = 0; i < SEG_MAX; i++) begin : g_seg
         if (i < SEG_ACT) begin : g_live
            assign seg[i] = addr[LOW_AW+i];
         end else begin : g_off
            assign seg[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int WAIT_W = 4,
   localparam int HALF  = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_write,
   input  logic [1:0]        cfg_mode,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              cfg_rdy_en,
   input  logic              cfg_rdy_pol,
   input  logic              rdy_s,
   input  logic [DATA_W-1:0] bus_din,
   output xbus_st_e          st,
   output logic              byte_sel,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              cur_write,
   output xbus_mode_t        cur_mode,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   logic [WAIT_W-1:0] wait_q;
   logic [WAIT_W-1:0] cnt_q;
   logic              rdy_en_q;
   logic              rdy_pol_q;
   logic              rdy_ok;
   logic              last_cycle;

   assign rdy_ok     = !rdy_en_q || (rdy_s == rdy_pol_q);
   assign last_cycle = !(cur_mode.narrow && !byte_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         byte_sel  <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         cur_write <= 1'b0;
         cur_mode  <= '0;
         wait_q    <= '0;
         cnt_q     <= '0;
         rdy_en_q  <= 1'b0;
         rdy_pol_q <= 1'b0;
         rdata     <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_addr  <= req_addr;
                  cur_wdata <= req_wdata;
                  cur_write <= req_write;
                  cur_mode  <= xbus_mode_t'(cfg_mode);
                  wait_q    <= cfg_wait;
                  rdy_en_q  <= cfg_rdy_en;
                  rdy_pol_q <= cfg_rdy_pol;
                  byte_sel  <= 1'b0;
                  st        <= ST_ALE;
               end
            end
            ST_ALE: begin
               if (cur_mode.mux) begin
                  st <= ST_AHOLD;
               end else begin
                  st    <= ST_STRB;
                  cnt_q <= wait_q;
               end
            end
            ST_AHOLD: begin
               st    <= ST_STRB;
               cnt_q <= wait_q;
            end
            ST_STRB: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (rdy_ok) begin
                  if (cur_write) begin
                     st <= ST_WHOLD;
                  end else begin
                     if (!cur_mode.narrow)  rdata             <= bus_din;
                     else if (byte_sel)     rdata[DATA_W-1:HALF] <= bus_din[HALF-1:0];
                     else                   rdata[HALF-1:0]   <= bus_din[HALF-1:0];
                     if (last_cycle) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                     end else begin
                        byte_sel <= 1'b1;
                        st       <= ST_ALE;
                     end
                  end
               end
            end
            ST_WHOLD: begin
               if (last_cycle) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  byte_sel <= 1'b1;
                  st       <= ST_ALE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbus_pad_drv.sv
module xbus_pad_drv
   import xbus_pkg::*;
#(
   parameter int LOW_AW  = 16,
   parameter int SEG_MAX = 8,
   parameter int DATA_W  = 16,
   localparam int HALF   = DATA_W / 2
) (
   input  xbus_st_e           st,
   input  xbus_mode_t         mode,
   input  logic               write,
   input  logic               byte_sel,
   input  logic [LOW_AW-1:0]  low,
   input  logic [SEG_MAX-1:0] seg,
   input  logic [DATA_W-1:0]  wdata,
   output logic               busy,
   output logic [LOW_AW-1:0]  bus_a,
   output logic [SEG_MAX-1:0] bus_seg,
   output logic [DATA_W-1:0]  xad_out,
   output logic               xad_oe,
   output logic               ale,
   output logic               rd_n,
   output logic               wr_n
);
   logic              active;
   logic              addr_ph;
   logic              drv_data;
   logic [DATA_W-1:0] wlane;

   assign active   = (st != ST_IDLE);
   assign addr_ph  = mode.mux && (st == ST_ALE || st == ST_AHOLD);
   assign drv_data = write && (st == ST_STRB || st == ST_WHOLD);

   assign wlane = mode.narrow
                ? {{HALF{1'b0}}, (byte_sel ? wdata[DATA_W-1:HALF] : wdata[HALF-1:0])}
                : wdata;

   assign busy    = active;
   assign ale     = mode.mux && (st == ST_ALE);
   assign rd_n    = !(st == ST_STRB && !write);
   assign wr_n    = !(st == ST_STRB && write);
   assign bus_seg = active ? seg : '0;
   assign bus_a   = (active && !mode.mux) ? low : '0;
   assign xad_oe  = addr_ph || drv_data;

   always_comb begin
      if (addr_ph)       xad_out = low;
      else if (drv_data) xad_out = wlane;
      else               xad_out = '0;
   end
endmodule

// File: rtl/xbus_engine.sv
module xbus_engine
   import xbus_pkg::*;
#(
   parameter int LOW_AW      = 16,
   parameter int SEG_MAX     = 8,
   parameter int SEG_ACT     = 7,
   parameter int DATA_W      = 16,
   parameter int WAIT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [LOW_AW+SEG_MAX-1:0] req_addr,
   input  logic [DATA_W-1:0]         req_wdata,
   input  logic                      req_write,
   input  logic [1:0]                cfg_mode,
   input  logic [WAIT_W-1:0]         cfg_wait,
   input  logic                      cfg_rdy_en,
   input  logic                      cfg_rdy_pol,
   output logic                      busy,
   output logic [DATA_W-1:0]         rsp_data,
   output logic                      rsp_done,
   output logic [LOW_AW-1:0]         bus_a,
   output logic [SEG_MAX-1:0]        bus_seg,
   output logic [DATA_W-1:0]         xad_out,
   input  logic [DATA_W-1:0]         xad_in,
   output logic                      xad_oe,
   output logic                      ale,
   output logic                      rd_n,
   output logic                      wr_n,
   input  logic                      bus_rdy
);
   localparam int ADDR_W = LOW_AW + SEG_MAX;

   generate
      if (LOW_AW != DATA_W) begin : g_bad_share
         $error("xbus_engine: shared lines need LOW_AW == DATA_W");
      end
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("xbus_engine: DATA_W must be even");
      end
   endgenerate

   logic              rdy_s;
   xbus_st_e          st;
   xbus_mode_t        cur_mode;
   logic              byte_sel;
   logic              cur_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic [LOW_AW-1:0] low_addr;
   logic [SEG_MAX-1:0] seg_addr;

   xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (bus_rdy),
      .dout (rdy_s)
   );

   xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_write  (req_write),
      .cfg_mode   (cfg_mode),
      .cfg_wait   (cfg_wait),
      .cfg_rdy_en (cfg_rdy_en),
      .cfg_rdy_pol(cfg_rdy_pol),
      .rdy_s      (rdy_s),
      .bus_din    (xad_in),
      .st         (st),
      .byte_sel   (byte_sel),
      .cur_addr   (cur_addr),
      .cur_wdata  (cur_wdata),
      .cur_write  (cur_write),
      .cur_mode   (cur_mode),
      .rdata      (rsp_data),
      .done       (rsp_done)
   );

   xbus_addr_map #(.LOW_AW(LOW_AW), .SEG_MAX(SEG_MAX), .SEG_ACT(SEG_ACT)) u_map (
      .addr    (cur_addr),
      .narrow  (cur_mode.narrow),
      .byte_sel(byte_sel),
      .low     (low_addr),
      .seg     (seg_addr)
   );

   xbus_pad_drv #(.LOW_AW(LOW_AW), .SEG_MAX(SEG_MAX), .DATA_W(DATA_W)) u_pad (
      .st      (st),
      .mode    (cur_mode),
      .write   (cur_write),
      .byte_sel(byte_sel),
      .low     (low_addr),
      .seg     (seg_addr),
      .wdata   (cur_wdata),
      .busy    (busy),
      .bus_a   (bus_a),
      .bus_seg (bus_seg),
      .xad_out (xad_out),
      .xad_oe  (xad_oe),
      .ale     (ale),
      .rd_n    (rd_n),
      .wr_n    (wr_n)
   );
endmodule

// File: rtl/xbus_engine_chk.sv
module xbus_engine_chk #(
   parameter int SEG_MAX = 8,
   parameter int SEG_ACT = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               ale,
   input logic               rd_n,
   input logic               wr_n,
   input logic               xad_oe,
   input logic               rsp_done,
   input logic [SEG_MAX-1:0] bus_seg
);
   // R2: never both strobes
   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n || wr_n);

   // R3: latch pulse lasts one clock, address still driven after it
   p_ale_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (!ale && xad_oe && rd_n && wr_n));

   // R3: latch pulse only with the shared bus driven and no strobe
   p_ale_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (xad_oe && rd_n && wr_n));

   // R9: bus released during read strobe
   p_rd_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !xad_oe);

   // R9: bus driven during write strobe
   p_wr_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> xad_oe);

   // R9: one hold clock after the write strobe
   p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> xad_oe);

   // R8: completion pulse is one clock wide
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R11: block is idle when it reports completion
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !busy);

   // R10: inactive segment lines stay low
   p_seg_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_seg >> SEG_ACT) == '0);
endmodule

bind xbus_engine xbus_engine_chk #(.SEG_MAX(SEG_MAX), .SEG_ACT(SEG_ACT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .ale     (ale),
   .rd_n    (rd_n),
   .wr_n    (wr_n),
   .xad_oe  (xad_oe),
   .rsp_done(rsp_done),
   .bus_seg (bus_seg)
);

// File: tb/xbus_engine_tb.sv
module xbus_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_write = 1'b0;
   logic [1:0]  cfg_mode = '0;
   logic [3:0]  cfg_wait = '0;
   logic        cfg_rdy_en = 1'b0;
   logic        cfg_rdy_pol = 1'b0;
   logic        busy;
   logic [15:0] rsp_data;
   logic        rsp_done;
   logic [15:0] bus_a;
   logic [7:0]  bus_seg;
   logic [15:0] xad_out;
   logic [15:0] xad_in;
   logic        xad_oe;
   logic        ale;
   logic        rd_n;
   logic        wr_n;
   logic        bus_rdy = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic tb_mux = 1'b0;
   logic tb_narrow = 1'b0;
   logic lat_odd = 1'b0;

   int r_ale, r_strb, r_oe, r_done, idx;
   logic r_first_busy;
   logic [15:0] a_bus [2];
   logic [7:0]  seg_s [2];
   logic [15:0] xo_s  [2];
   logic [15:0] ale_a [2];
   logic [15:0] a_last;

   always #4 clk = ~clk;

   xbus_engine u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .cfg_mode(cfg_mode),
      .cfg_wait(cfg_wait), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_pol(cfg_rdy_pol),
      .busy(busy), .rsp_data(rsp_data), .rsp_done(rsp_done), .bus_a(bus_a),
      .bus_seg(bus_seg), .xad_out(xad_out), .xad_in(xad_in), .xad_oe(xad_oe),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bus_rdy(bus_rdy)
   );

   // device model: narrow path answers 5A (even) / C3 (odd), upper lane junk
   always_comb begin
      if (tb_narrow) xad_in = {8'hEE, ((tb_mux ? lat_odd : bus_a[0]) ? 8'hC3 : 8'h5A)};
      else           xad_in = 16'hBEEF;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // issue one request at a negedge and observe until completion
   task automatic run(input logic [1:0] m, input logic [3:0] wt, input logic ren,
                      input logic pol, input logic wr, input logic [23:0] ad,
                      input logic [15:0] wd, input int raise_after, input int poke);
      logic strb, prev;
      tb_mux = m[0]; tb_narrow = m[1];
      r_ale = 0; r_strb = 0; r_oe = 0; r_done = 0; idx = 0; prev = 1'b0;
      cfg_mode = m; cfg_wait = wt; cfg_rdy_en = ren; cfg_rdy_pol = pol;
      req_write = wr; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
      if (raise_after == 0)     bus_rdy = pol;
      else if (raise_after > 0) bus_rdy = !pol;
      for (int n = 1; n <= 300; n++) begin
         @(negedge clk);
         if (n == 1) begin req_valid = 1'b0; r_first_busy = busy; end
         if (n == poke) begin req_valid = 1'b1; req_addr = 24'h00_7FFE; end
         if (n == poke + 1) req_valid = 1'b0;
         strb = !rd_n || !wr_n;
         if (ale) begin
            if (r_ale < 2) ale_a[r_ale] = xad_out;
            lat_odd = xad_out[0];
            r_ale++;
         end
         if (strb) begin
            r_strb++;
            a_last = bus_a;
            if (!prev && idx < 2) begin
               a_bus[idx] = bus_a; seg_s[idx] = bus_seg; xo_s[idx] = xad_out; idx++;
            end
            if (raise_after > 0 && r_strb == raise_after) bus_rdy = pol;
         end
         prev = strb;
         if (xad_oe) r_oe++;
         if (rsp_done) begin r_done++; break; end
      end
      if (r_done == 0) begin
         checks++; errors++;
         $display("FAIL R8 access timeout actual=0 expected=1");
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 in reset", {busy, ale, xad_oe, rsp_done, rd_n, wr_n}, 6'b000011);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after reset", {busy, ale, xad_oe, rsp_done, rd_n, wr_n}, 6'b000011);
   endtask

   task automatic t_demux16_read();
      run(2'b00, 4'd2, 1'b0, 1'b0, 1'b0, 24'hA3_4567, 16'h0, -1, -1);
      chk("R2 no ale", r_ale, 0);
      chk("R2 address on bus_a", a_bus[0], 16'h4566);
      chk("R6 strobe length", r_strb, 3);
      chk("R10 segment lines", seg_s[0], 8'h23);
      chk("R8 read data", rsp_data, 16'hBEEF);
      chk("R9 read leaves bus free", r_oe, 0);
   endtask

   task automatic t_mux16_write();
      run(2'b01, 4'd1, 1'b0, 1'b0, 1'b1, 24'h00_1234, 16'hCAFE, -1, -1);
      chk("R3 one ale", r_ale, 1);
      chk("R3 address at ale", ale_a[0], 16'h1234);
      chk("R9 write data", xo_s[0], 16'hCAFE);
      chk("R9 drive cycles", r_oe, 5);
      chk("R6 strobe length", r_strb, 2);
   endtask

   task automatic t_mux8_read();
      run(2'b11, 4'd0, 1'b0, 1'b0, 1'b0, 24'h00_2001, 16'h0, -1, -1);
      chk("R5 two ale", r_ale, 2);
      chk("R5 even first", ale_a[0], 16'h2000);
      chk("R5 odd second", ale_a[1], 16'h2001);
      chk("R4 R8 assembled word", rsp_data, 16'hC35A);
      chk("R9 address drive only", r_oe, 4);
      @(negedge clk);
      chk("R5 single done", {rsp_done, busy}, 2'b00);
   endtask

   task automatic t_demux8_write();
      run(2'b10, 4'd0, 1'b0, 1'b0, 1'b1, 24'h00_3000, 16'hA1B2, -1, -1);
      chk("R5 even address", a_bus[0], 16'h3000);
      chk("R5 odd address", a_bus[1], 16'h3001);
      chk("R4 low byte lane", xo_s[0], 16'h00B2);
      chk("R4 high byte on low lane", xo_s[1], 16'h00A1);
      chk("R9 drive cycles", r_oe, 4);
      chk("R6 two strobes", r_strb, 2);
   endtask

   task automatic t_wait_noready();
      run(2'b00, 4'd5, 1'b0, 1'b1, 1'b0, 24'h00_0010, 16'h0, 1, -1);
      chk("R6 ready ignored when disabled", r_strb, 6);
   endtask

   task automatic t_ready_high();
      run(2'b00, 4'd0, 1'b1, 1'b1, 1'b0, 24'h00_0020, 16'h0, 6, -1);
      chk("R7 late ready active high", r_strb, 8);
   endtask

   task automatic t_ready_low();
      run(2'b00, 4'd0, 1'b1, 1'b0, 1'b1, 24'h00_0030, 16'h5555, 6, -1);
      chk("R7 late ready active low", r_strb, 8);
   endtask

   task automatic t_ready_early();
      run(2'b00, 4'd3, 1'b1, 1'b1, 1'b0, 24'h00_0040, 16'h0, 0, -1);
      chk("R7 waits then ready", r_strb, 4);
   endtask

   task automatic t_ignore_busy();
      run(2'b00, 4'd4, 1'b0, 1'b0, 1'b0, 24'h00_0456, 16'h0, -1, 2);
      chk("R11 address kept while busy", a_last, 16'h0456);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R11 no extra access", busy, 1'b0);
      end
   endtask

   task automatic t_b2b();
      run(2'b01, 4'd0, 1'b0, 1'b0, 1'b0, 24'h00_0100, 16'h0, -1, -1);
      chk("R8 first read", rsp_data, 16'hBEEF);
      run(2'b10, 4'd0, 1'b0, 1'b0, 1'b1, 24'h00_0202, 16'h1357, -1, -1);
      chk("R11 taken in done cycle", r_first_busy, 1'b1);
      chk("R11 switched mode even", a_bus[0], 16'h0202);
      chk("R11 switched mode odd", a_bus[1], 16'h0203);
      chk("R11 low byte", xo_s[0], 16'h0057);
      chk("R11 high byte", xo_s[1], 16'h0013);
   endtask

   initial begin
      t_reset();
      t_demux16_read();
      t_mux16_write();
      t_mux8_read();
      t_demux8_write();
      t_wait_noready();
      t_ready_high();
      t_ready_low();
      t_ready_early();
      t_ignore_busy();
      t_b2b();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end
endmodule